// File: doc/BRIEF.md
# Register Command-Stream Executor

The block runs a list of register-programming instructions that software has placed in memory. Software first sets an enable bit and loads a start address. It then writes an end address, and that write starts the run. The engine reads the list one 64-bit word at a time through a read port with one cycle of latency. It decodes each instruction and issues writes on a simple register bus that can only write. It never reads a register.

Four kinds of work are supported:
- a no-op;
- a single write with per-byte enables;
- a burst of data words all sent to one register offset, where the target register advances internally;
- a pause measured in microseconds.

Any other code is skipped and raises a sticky error flag. A busy output tells the host when the engine may be started again. A current-address output shows which instruction is in execution, so a stalled list can be located.

Top module: `regstream_exec`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `busy`, `reg_wr`, `mem_rd` and `err` are all 0.
- R2: The configuration selects are 0 for control, 1 for start address and 2 for end address. Control bit 0 is enable and bit 1 is halt. An end-address write starts a run only when enable is set and the engine is idle. `busy` is 1 from the next cycle, and fetching begins at the start address. Address bits 5:0 of both addresses are ignored. With enable clear, an end-address write starts nothing.
- R3: Each 64-bit memory word is one instruction. Bits 31:0 hold the data or count. Bits 63:56 hold the opcode, bits 55:52 the byte enables and bits 51:32 the register offset. Opcode 0x01 makes one register write of the data to the offset, using those byte enables. The write happens in the second cycle of the instruction.
- R4: Every instruction takes a request cycle and a decode cycle. A no-op (0x00) takes exactly these two cycles, and `reg_wr` is 0 in any cycle with no write due.
- R5: Opcode 0x09 carries a count N in bits 31:0. The N data words follow in the next memory words, lower half first. When N is odd, the upper half of the last word is padding and is skipped. Each data word is written to the same offset with byte enables 0xF. Each following memory word costs three cycles, or two for an odd last word. N = 0 writes nothing.
- R6: Opcode 0x02 pauses for N microseconds, with N in bits 31:0. The next instruction is requested N·CLK_MHZ + 3 cycles after the pause's own request cycle. N = 0 acts as a no-op.
- R7: Any other opcode is skipped in two cycles and sets `err`. `err` stays set until a control write of 0.
- R8: A run ends at the first request cycle whose address equals the end address. `busy` is 0 from the next cycle. If the start and end addresses are equal, `busy` is high for one cycle only.
- R9: A control write with halt set, or with enable clear, aborts a run. `busy` is 0 from the next cycle, and no further writes are made.
- R10: An end-address write while busy is ignored, and the run continues unchanged.
- R11: `cur_head` gives the byte address of the instruction most recently decoded, such as a pause in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 start address, 2 end address |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Run in progress |
| err | output | 1 | Sticky unknown-opcode flag |
| cur_head | output | ADDR_W | Byte address of the instruction last decoded |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | ADDR_W-3 | Address of the 64-bit memory word |
| mem_rdata | input | 64 | Read data, valid the cycle after `mem_rd` |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 20 | Register offset |
| reg_be | output | 4 | Byte enables; bit k gates byte lane k |
| reg_wdata | output | 32 | Register write data |

## Verification
The bench builds the engine with CLK_MHZ = 4 and ADDR_W = 16. The small clock figure makes a three-microsecond pause only a dozen cycles long, so its exact end cycle can be checked against the write that follows it. The same setting turns a 1000-microsecond pause into a long, stable window in which to read the current address and to halt the run. A 16-bit address space leaves room for several programs, each on its own 64-byte line.

// File: rtl/rse_pkg.sv
package rse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_INST, ST_DREQ, ST_DLO, ST_DHI, ST_WAIT
  } rse_state_e;

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_WR   = 8'h01;
  localparam logic [7:0] OP_WAIT = 8'h02;
  localparam logic [7:0] OP_IDX  = 8'h09;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;
endpackage

// File: rtl/rse_cfg.sv
module rse_cfg
  import rse_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  output logic              start,
  output logic              abort,
  output logic              clr_err,
  output logic [ADDR_W-7:0] head_line,
  output logic [ADDR_W-7:0] tail_line
);
  localparam int LINE_W = ADDR_W - 6;

  logic              en_q, en_d;
  logic [LINE_W-1:0] head_q, head_d, tail_q, tail_d;
  logic              wr_ctrl, wr_head, wr_tail;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_wdata[31:ADDR_W], cfg_wdata[5:2]};

  assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_head = cfg_we && (cfg_sel == SEL_HEAD);
  assign wr_tail = cfg_we && (cfg_sel == SEL_TAIL);

  always_comb begin
    en_d   = en_q;
    head_d = head_q;
    tail_d = tail_q;
    if (wr_ctrl)          en_d   = cfg_wdata[0];
    if (wr_head)          head_d = cfg_wdata[ADDR_W-1:6];
    if (wr_tail && !busy) tail_d = cfg_wdata[ADDR_W-1:6];
  end

  assign start   = wr_tail && en_q && !busy;
  assign abort   = wr_ctrl && (!cfg_wdata[0] || cfg_wdata[1]);
  assign clr_err = wr_ctrl && (cfg_wdata[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      en_q   <= en_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_line = head_q;
  assign tail_line = tail_q;
endmodule

// File: rtl/rse_usec_timer.sv
module rse_usec_timer #(
  parameter int CLK_MHZ = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        abort,
  output logic        idle
);
  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_MHZ - 1);

  logic [31:0]      rem_q, rem_d;
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    rem_d = rem_q;
    pre_d = pre_q;
    if (abort) begin
      rem_d = '0;
    end else if (load) begin
      rem_d = load_val;
      pre_d = PRE_MAX;
    end else if (rem_q != '0) begin
      if (pre_q == '0) begin
        pre_d = PRE_MAX;
        rem_d = rem_q - 32'd1;
      end else begin
        pre_d = pre_q - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      pre_q <= '0;
    end else begin
      rem_q <= rem_d;
      pre_q <= pre_d;
    end
  end

  assign idle = (rem_q == '0);

  // R6: remaining time never grows except on a new load
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !abort && rem_q != '0) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/regstream_exec.sv
module regstream_exec
  import rse_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CLK_MHZ = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              busy,
  output logic              err,
  output logic [ADDR_W-1:0] cur_head,
  output logic              mem_rd,
  output logic [ADDR_W-4:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic              reg_wr,
  output logic [19:0]       reg_addr,
  output logic [3:0]        reg_be,
  output logic [31:0]       reg_wdata
);
  localparam int QW     = ADDR_W - 3;
  localparam int LINE_W = ADDR_W - 6;

  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic              start, abort, clr_err, tmr_load, tmr_idle;
  logic [LINE_W-1:0] head_line, tail_line;

  rse_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .start(start), .abort(abort),
    .clr_err(clr_err), .head_line(head_line), .tail_line(tail_line)
  );

  rse_usec_timer #(.CLK_MHZ(CLK_MHZ)) u_tmr (
    .clk(clk), .rst_n(rst_core_n), .load(tmr_load),
    .load_val(mem_rdata[31:0]), .abort(abort), .idle(tmr_idle)
  );

  rse_state_e  state_q, state_d;
  logic [QW-1:0] ptr_q, ptr_d, cur_q, cur_d;
  logic [31:0]   cnt_q, cnt_d, hi_q, hi_d;
  logic [19:0]   radr_q, radr_d;
  logic          err_q, err_d;

  logic [7:0]  op;
  logic [3:0]  be;
  logic [19:0] off;
  logic [31:0] lo;
  logic        at_tail;

  assign op      = mem_rdata[63:56];
  assign be      = mem_rdata[55:52];
  assign off     = mem_rdata[51:32];
  assign lo      = mem_rdata[31:0];
  assign at_tail = (ptr_q == {tail_line, 3'b000});

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    cur_d    = cur_q;
    cnt_d    = cnt_q;
    hi_d     = hi_q;
    radr_d   = radr_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        ptr_d   = {head_line, 3'b000};
        state_d = ST_REQ;
      end
      ST_REQ: state_d = at_tail ? ST_IDLE : ST_INST;
      ST_INST: begin
        cur_d   = ptr_q;
        ptr_d   = ptr_q + QW'(1);
        state_d = ST_REQ;
        case (op)
          OP_NOP, OP_WR: ;
          OP_IDX: if (lo != '0) begin
            cnt_d   = lo;
            radr_d  = off;
            state_d = ST_DREQ;
          end
          OP_WAIT: if (lo != '0) begin
            tmr_load = 1'b1;
            state_d  = ST_WAIT;
          end
          default: err_d = 1'b1;
        endcase
      end
      ST_DREQ: state_d = ST_DLO;
      ST_DLO: begin
        hi_d    = mem_rdata[63:32];
        ptr_d   = ptr_q + QW'(1);
        cnt_d   = cnt_q - 32'd1;
        state_d = (cnt_q == 32'd1) ? ST_REQ : ST_DHI;
      end
      ST_DHI: begin
        cnt_d   = cnt_q - 32'd1;
        state_d = (cnt_q == 32'd1) ? ST_REQ : ST_DREQ;
      end
      ST_WAIT: if (tmr_idle) state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
    if (abort)   state_d = ST_IDLE;
    if (clr_err) err_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cur_q   <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
      radr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
      radr_q  <= radr_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_be    = '0;
    reg_wdata = '0;
    if (state_q == ST_INST && op == OP_WR) begin
      reg_wr = 1'b1; reg_addr = off; reg_be = be; reg_wdata = lo;
    end else if (state_q == ST_DLO) begin
      reg_wr = 1'b1; reg_addr = radr_q; reg_be = 4'hF; reg_wdata = lo;
    end else if (state_q == ST_DHI) begin
      reg_wr = 1'b1; reg_addr = radr_q; reg_be = 4'hF; reg_wdata = hi_q;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign err      = err_q;
  assign cur_head = {cur_q, 3'b000};
  assign mem_rd   = (state_q == ST_REQ && !at_tail) || (state_q == ST_DREQ);
  assign mem_addr = ptr_q;

  // R2: an accepted start makes the engine busy in the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_core_n)
    start |=> busy);
  // R9: abort leaves the engine idle with a quiet bus
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    abort |=> (!busy && !reg_wr));
  // R8: a run ends only at the end address or by abort
  a_r8_stop_at_tail: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(busy) |-> ($past(abort) || $past(at_tail)));
  // R7: the error flag holds until cleared
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    (err && !clr_err) |=> err);
  // R10: end address frozen while running
  a_r10_tail_frozen: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |=> $stable(tail_line));
endmodule

// File: tb/regstream_exec_tb.sv
module regstream_exec_tb;
  localparam int AW   = 16;
  localparam int CMHZ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        busy, err, mem_rd, reg_wr;
  logic [AW-1:0] cur_head;
  logic [AW-4:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [19:0] reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;

  always #5 clk = ~clk;

  regstream_exec #(.ADDR_W(AW), .CLK_MHZ(CMHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .err(err), .cur_head(cur_head),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata)
  );

  logic [63:0] mem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  int vec = 0;
  int bad = 0;
  int wd  = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < 100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    int          t;
    logic [19:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    string       tag;
  } ev_t;

  ev_t evq[$];
  int  wp;
  int  mt;

  task automatic put(input logic [31:0] hi, input logic [31:0] lo);
    mem[wp] = {hi, lo};
    wp++;
  endtask

  function automatic logic [31:0] up(input logic [7:0] op, input logic [3:0] be,
                                     input logic [19:0] off);
    return {op, be, off};
  endfunction

  task automatic begin_prog(input int q);
    wp = q; mt = 0; evq.delete();
  endtask

  task automatic e_nop();
    put(32'h0, 32'h0); mt += 2;
  endtask

  task automatic e_wr(input logic [19:0] off, input logic [3:0] be,
                      input logic [31:0] d, input string tag);
    ev_t e;
    put(up(8'h01, be, off), d);
    e.t = mt + 1; e.a = off; e.d = d; e.be = be; e.tag = tag;
    evq.push_back(e);
    mt += 2;
  endtask

  task automatic e_idx(input logic [19:0] off, input int n, input logic [31:0] base);
    put(up(8'h09, 4'h0, off), n);
    for (int k = 0; k < (n + 1) / 2; k++)
      put((2*k + 1 < n) ? base + 32'(2*k + 1) : 32'h0, base + 32'(2*k));
    for (int i = 0; i < n; i++) begin
      ev_t e;
      e.t = mt + 3 + 3*(i/2) + (i%2); e.a = off; e.d = base + 32'(i);
      e.be = 4'hF; e.tag = "R5";
      evq.push_back(e);
    end
    mt += 2 + 3*(n/2) + 2*(n%2);
  endtask

  task automatic e_wait(input int n);
    put(up(8'h02, 4'h0, 20'h0), n);
    mt += (n == 0) ? 2 : 3 + n*CMHZ;
  endtask

  task automatic e_bad();
    put(up(8'h05, 4'h0, 20'h0), 32'h0); mt += 2;
  endtask

  task automatic end_prog();
    while (wp % 8 != 0) e_nop();
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] tail, input bit mid);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = tail;
    for (int c = 0; c <= mt + 3; c++) begin
      @(negedge clk);
      if (c == 0) cfg_we = 1'b0;
      if (mid && c == 5) begin  // R10: end-address write while busy
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h40;
      end
      if (mid && c == 6) cfg_we = 1'b0;
      if (evq.size() > 0 && evq[0].t == c) begin
        chk(reg_wr === 1'b1 && reg_addr === evq[0].a && reg_wdata === evq[0].d
            && reg_be === evq[0].be, evq[0].tag, "register write",
            {7'b0, reg_wr, reg_be, reg_addr, reg_wdata},
            {7'b0, 1'b1, evq[0].be, evq[0].a, evq[0].d});
        void'(evq.pop_front());
      end else begin
        chk(reg_wr === 1'b0, "R4", "no write due", 64'(reg_wr), 64'd0);
      end
      chk(busy === (c <= mt), "R8", "busy", 64'(busy), 64'(c <= mt));
    end
    chk(evq.size() == 0, "R3", "writes outstanding", 64'(evq.size()), 64'd0);
  endtask

  initial begin
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'h0;
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && reg_wr === 1'b0 && mem_rd === 1'b0 && err === 1'b0,
        "R1", "reset outputs", {busy, reg_wr, mem_rd, err}, 4'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && mem_rd === 1'b0, "R1", "idle after reset",
        {busy, mem_rd}, 2'b00);
    cfg(2'd0, 32'h1);

    // Program 1 at 0x000: mixed instructions; head low bits ignored (R2)
    begin_prog(0);
    e_wr(20'h01234, 4'hF, 32'hA5A5_0001, "R3");
    e_nop();
    e_wr(20'h00100, 4'h5, 32'hDEAD_BEEF, "R3");
    e_idx(20'h00200, 3, 32'h1000_0000);
    e_idx(20'h00300, 2, 32'h2000_0000);
    e_idx(20'h00400, 0, 32'h0);
    e_wait(3);
    e_wr(20'h00500, 4'hC, 32'h600D_F00D, "R6");
    end_prog();
    cfg(2'd1, 32'h3F);
    run(32'h80, 1'b1);  // R2, R3, R4, R5, R6, R8, R10
    chk(err === 1'b0, "R7", "no error on valid list", 64'(err), 64'd0);

    // Program 3: start equals end (R8)
    begin_prog(128);
    cfg(2'd1, 32'h400);
    run(32'h400, 1'b0);

    // Program 2: unknown opcode (R7)
    begin_prog(64);
    e_bad();
    e_wr(20'h00777, 4'hF, 32'h1111_2222, "R7");
    end_prog();
    cfg(2'd1, 32'h200);
    run(32'h240, 1'b0);
    chk(err === 1'b1, "R7", "error set", 64'(err), 64'd1);
    cfg(2'd0, 32'h1);
    chk(err === 1'b1, "R7", "error held by enable write", 64'(err), 64'd1);
    cfg(2'd0, 32'h0);
    chk(err === 1'b0, "R7", "error cleared", 64'(err), 64'd0);

    // Enable clear: end-address write starts nothing (R2)
    cfg(2'd1, 32'h600);
    cfg(2'd2, 32'h640);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(busy === 1'b0 && mem_rd === 1'b0 && reg_wr === 1'b0, "R2",
          "no start without enable", {busy, mem_rd, reg_wr}, 3'b000);
    end
    cfg(2'd0, 32'h1);

    // Program 5: halt during a long pause (R9, R11)
    begin_prog(160);
    e_nop();
    e_wait(1000);
    e_wr(20'h00999, 4'hF, 32'hBAD0_BAD0, "R9");
    end_prog();
    cfg(2'd1, 32'h500);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h540;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R6", "busy in pause", 64'(busy), 64'd1);
    chk(cur_head === 16'h0508, "R11", "current address", 64'(cur_head), 64'h508);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h3;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int c = 0; c < 20; c++) begin
      chk(busy === 1'b0 && reg_wr === 1'b0, "R9", "halted",
          {busy, reg_wr}, 2'b00);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule